// File: doc/BRIEF.md
# UART Channel Command Decoder

This block sits behind the command byte of one serial channel. Each write strobe delivers one byte that holds three independent command fields. The receiver field and the transmitter field switch their direction on or off. The third field carries one of a small set of housekeeping actions. All fields in a byte are applied together at the clock edge where the strobe is sampled.

The block holds three pieces of state: the receiver-enable flag, the transmitter-enable flag, and the mode-register pointer. It also produces single-cycle strobes that flush the receive or transmit FIFO, clear the error bits in the status register, and clear the break-change bit in the interrupt status register. The FIFOs, the status storage and the interrupt logic are outside this block and take only these strobes. The mode-register pointer steps forward on each mode-register access reported by the surrounding register file. It stops at the last mode register.

Top module: `uart_cmd_decoder`

## Requirements
- R1: After reset both enable flags are 0, the pointer is 0 (first mode register) and every strobe output is 0.
- R2: Bits 1:0 are the receiver field. 01 sets the receiver flag, 10 clears it, and 00 and 11 leave it unchanged. The new value is visible in the cycle after the write.
- R3: Bits 3:2 are the transmitter field and use the same encoding as the receiver field, acting on the transmitter flag.
- R4: Housekeeping code 0001 in bits 7:4 returns the pointer to 0.
- R5: Code 0010 clears the receiver flag and pulses rx_flush in the cycle after the write. It wins over a receiver enable given in the same byte.
- R6: Code 0011 clears the transmitter flag and pulses tx_flush in the cycle after the write. It wins over a transmitter enable given in the same byte.
- R7: Code 0100 pulses err_clear in the cycle after the write.
- R8: Code 0101 pulses brk_chg_clr_mask in the cycle after the write, with only bit 2 set for channel 0 and only bit 6 set for channel 1.
- R9: Each strobe stays high for exactly one cycle per write. Back-to-back writes give back-to-back pulses.
- R10: Codes 0000 and 0110 to 1111 change no flag, pointer or strobe.
- R11: Each cycle with mr_access high advances the pointer by one, up to NUM_MR-1, where it holds. A code 0001 write in the same cycle wins and the pointer becomes 0.
- R12: Receiver, transmitter and housekeeping fields in one byte all take effect at the same edge.
- R13: Without a write strobe the flags stay unchanged and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte |
| mr_access | input | 1 | A mode-register access occurred this cycle |
| rx_enabled | output | 1 | Receiver enable flag |
| tx_enabled | output | 1 | Transmitter enable flag |
| mr_ptr | output | $clog2(NUM_MR) | Current mode-register pointer |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |
| err_clear | output | 1 | Error-status clear strobe |
| brk_chg_clr_mask | output | ISR_W | Per-bit clear strobe for the interrupt status register |

## Verification
A wrong enable flag shows on rx_enabled or tx_enabled in the first cycle after the write that caused it. A flag that fails to clear on a reset code shows at the same moment as its flush strobe. A pointer that is off by one, fails to saturate, or loses a same-cycle reset shows on mr_ptr one cycle after the access. Strobes that are stretched, missing or sent to the wrong mask bit show in the single cycle after the write. The bench therefore compares every output on every cycle.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  localparam logic [1:0] DIR_ON  = 2'b01;
  localparam logic [1:0] DIR_OFF = 2'b10;

  localparam logic [3:0] HK_PTR_HOME = 4'd1;
  localparam logic [3:0] HK_RX_RESET = 4'd2;
  localparam logic [3:0] HK_TX_RESET = 4'd3;
  localparam logic [3:0] HK_ERR_CLR  = 4'd4;
  localparam logic [3:0] HK_BRK_CLR  = 4'd5;

  localparam int NUM_DIR = 2;

  function automatic logic [3:0] hk_code(input logic [7:0] cmd_byte);
    return cmd_byte[7:4];
  endfunction
endpackage

// File: rtl/ucd_dir_ctl.sv
module ucd_dir_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] field,
  input  logic       hard_reset,
  output logic       en,
  output logic       flush
);
  import ucd_pkg::*;

  logic en_q, en_d;
  logic flush_q, flush_d;

  always_comb begin
    en_d    = en_q;
    flush_d = 1'b0;
    if (wr_en) begin
      if (field == DIR_ON)  en_d = 1'b1;
      if (field == DIR_OFF) en_d = 1'b0;
      if (hard_reset) begin
        en_d    = 1'b0;
        flush_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      flush_q <= flush_d;
    end
  end

  assign en    = en_q;
  assign flush = flush_q;

  // R5 / R6: a flush pulse always coincides with a cleared flag
  a_r5_flush_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !en_q);
  // R13: no write strobe, no change to the flag
  a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q) && !flush_q);
  // R9: a flush is always caused by a write one cycle earlier
  a_r9_flush_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(wr_en));
endmodule

// File: rtl/ucd_mr_ptr.sv
module ucd_mr_ptr #(
  parameter int NUM_MR = 3,
  localparam int PTR_W = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             home,
  input  logic             advance,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_MR - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_ce;

  assign ptr_ce = home || (advance && (ptr_q != PTR_LAST));

  always_comb begin
    ptr_d = ptr_q;
    if (home)        ptr_d = '0;
    else if (advance) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R11: the pointer never passes the last mode register
  a_r11_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_LAST);
  // R4: a home request lands on the first register
  a_r4_home: assert property (@(posedge clk) disable iff (!rst_n)
    home |=> ptr_q == '0);
endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder #(
  parameter int NUM_MR    = 3,
  parameter int ISR_W     = 8,
  parameter int CHANNEL   = 0,
  parameter int BRK_BIT_0 = 2,
  parameter int BRK_BIT_1 = 6,
  localparam int PTR_W    = (NUM_MR > 1) ? $clog2(NUM_MR) : 1,
  localparam int BRK_BIT  = (CHANNEL == 0) ? BRK_BIT_0 : BRK_BIT_1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             mr_access,
  output logic             rx_enabled,
  output logic             tx_enabled,
  output logic [PTR_W-1:0] mr_ptr,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             err_clear,
  output logic [ISR_W-1:0] brk_chg_clr_mask
);
  import ucd_pkg::*;

  logic [3:0]         hk;
  logic [NUM_DIR-1:0] dir_en, dir_flush;

  assign hk = hk_code(wr_data);

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam logic [3:0] RESET_CODE = (d == 0) ? HK_RX_RESET : HK_TX_RESET;
    ucd_dir_ctl u_dir (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .field      (wr_data[2*d +: 2]),
      .hard_reset (hk == RESET_CODE),
      .en         (dir_en[d]),
      .flush      (dir_flush[d])
    );
  end

  ucd_mr_ptr #(.NUM_MR(NUM_MR)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .home    (wr_en && (hk == HK_PTR_HOME)),
    .advance (mr_access),
    .ptr     (mr_ptr)
  );

  logic err_q, err_d, brk_q, brk_d;

  always_comb begin
    err_d = wr_en && (hk == HK_ERR_CLR);
    brk_d = wr_en && (hk == HK_BRK_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      err_q <= err_d;
      brk_q <= brk_d;
    end
  end

  assign rx_enabled = dir_en[0];
  assign tx_enabled = dir_en[1];
  assign rx_flush   = dir_flush[0];
  assign tx_flush   = dir_flush[1];
  assign err_clear  = err_q;

  always_comb begin
    brk_chg_clr_mask          = '0;
    brk_chg_clr_mask[BRK_BIT] = brk_q;
  end

  // R8: at most one interrupt bit is cleared at a time
  a_r8_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(brk_chg_clr_mask));
  // R10 / R12: only one housekeeping action can come from one byte
  a_r10_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_flush, tx_flush, err_clear, |brk_chg_clr_mask}) <= 1);
  // R7: an error clear strobe is preceded by a write
  a_r7_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |-> $past(wr_en));
endmodule

// File: tb/uart_cmd_decoder_tb.sv
module uart_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MR     = 3;
  localparam int PTR_W      = $clog2(NUM_MR);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic             mr_access;
  logic             rx_enabled, tx_enabled;
  logic [PTR_W-1:0] mr_ptr;
  logic             rx_flush, tx_flush, err_clear;
  logic [7:0]       brk_chg_clr_mask;

  int errors = 0;
  int checks = 0;

  // reference model state
  int m_rx = 0, m_tx = 0, m_ptr = 0;
  int m_rxf = 0, m_txf = 0, m_err = 0, m_brk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cmd_decoder #(.NUM_MR(NUM_MR), .CHANNEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mr_access(mr_access), .rx_enabled(rx_enabled), .tx_enabled(tx_enabled),
    .mr_ptr(mr_ptr), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .err_clear(err_clear), .brk_chg_clr_mask(brk_chg_clr_mask)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "rx_enabled", int'(rx_enabled), m_rx);
    cmp(tag, "tx_enabled", int'(tx_enabled), m_tx);
    cmp(tag, "mr_ptr", int'(mr_ptr), m_ptr);
    cmp(tag, "rx_flush", int'(rx_flush), m_rxf);
    cmp(tag, "tx_flush", int'(tx_flush), m_txf);
    cmp(tag, "err_clear", int'(err_clear), m_err);
    cmp(tag, "brk_mask", int'(brk_chg_clr_mask), m_brk ? 32'h04 : 0);
  endtask

  task automatic model_edge(input int w, input int d, input int acc);
    int rf, tf, hk;
    rf = d & 3; tf = (d >> 2) & 3; hk = (d >> 4) & 15;
    m_rxf = 0; m_txf = 0; m_err = 0; m_brk = 0;
    if (acc && m_ptr < NUM_MR - 1) m_ptr++;
    if (w) begin
      if (rf == 1) m_rx = 1; else if (rf == 2) m_rx = 0;
      if (tf == 1) m_tx = 1; else if (tf == 2) m_tx = 0;
      case (hk)
        1: m_ptr = 0;
        2: begin m_rx = 0; m_rxf = 1; end
        3: begin m_tx = 0; m_txf = 1; end
        4: m_err = 1;
        5: m_brk = 1;
        default: ;
      endcase
    end
  endtask

  // drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input int w, input int d, input int acc, input string tag);
    wr_en = w[0]; wr_data = d[7:0]; mr_access = acc[0];
    @(posedge clk);
    model_edge(w, d, acc);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; mr_access = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1, 8'h01, 0, "R2");  // rx on
    step(1, 8'h03, 0, "R2");  // reserved: keep
    step(1, 8'h00, 0, "R2");  // keep
    step(1, 8'h02, 0, "R2");  // rx off
    step(1, 8'h04, 0, "R3");  // tx on
    step(1, 8'h0C, 0, "R3");  // reserved: keep
    step(1, 8'h08, 0, "R3");  // tx off

    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, "R11");  // saturates at 2
    step(1, 8'h10, 0, "R4");
    step(0, 8'h00, 1, "R11");
    step(1, 8'h10, 1, "R11");  // home wins over access

    step(1, 8'h05, 0, "R12");  // rx and tx on together
    step(1, 8'h21, 0, "R5");   // rx reset beats rx enable
    step(0, 8'h00, 0, "R9");
    step(1, 8'h34, 0, "R6");   // tx reset beats tx enable
    step(0, 8'h00, 0, "R9");
    step(1, 8'h45, 0, "R12");  // enables plus error clear
    step(1, 8'h40, 0, "R7");
    step(1, 8'h40, 0, "R9");   // back-to-back
    step(0, 8'h00, 0, "R9");
    step(1, 8'h50, 0, "R8");
    step(0, 8'h00, 0, "R9");

    step(0, 8'h00, 1, "R10");
    for (int c = 6; c < 16; c++) step(1, c << 4, 0, "R10");
    step(1, 8'h00, 0, "R10");

    step(0, 8'h2A, 0, "R13");  // data without strobe is ignored
    step(0, 8'h30, 0, "R13");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule